// File: doc/BRIEF.md
# Immediate and Shift Execute Unit

This block is a purely combinational execute slice for a small 32-bit load/store core. It receives one fixed-width 32-bit instruction word together with the values already read from the two source registers (`src_a`, taken from the rs field, and `src_b`, taken from the rt field). In the same cycle it returns the destination register number, a write strobe and the 32-bit value to write back.

Two groups of operations are handled. The first group uses the immediate format: load-upper, add-immediate, AND-immediate and OR-immediate. These write the rt register. The second group is the register-format shift family. It covers left logical, right logical and right arithmetic shifts. The shift amount comes either from the 5-bit shift-amount field or from the low bits of `src_a`. These write the rd register.

Decoding is a single classification step. The word is sorted into one enumerated operation kind, and a `unique case` on that kind steers the datapath. Any word that matches none of the kinds becomes the kind `K_NONE`, and that kind suppresses the write. Memory access, control flow, the register file and exception signalling are outside this block.

Top module: `exu_imm_shift`

## Requirements
- R1: Opcode 0x0F (bits 31:26) is load-upper. It writes `{imm[15:0], 16'h0000}` to the rt index (bits 20:16) with `wr_en` = 1, whatever `src_a` holds.
- R2: Opcode 0x0C is AND-immediate. It writes `src_a & {16'h0000, imm}` to the rt index, so bits 31:16 of the result are always 0.
- R3: Opcode 0x0D is OR-immediate. It writes `src_a | {16'h0000, imm}` to the rt index, so bits 31:16 equal `src_a[31:16]`.
- R4: Opcode 0x08 is add-immediate. It writes `src_a` plus the sign-extended immediate, modulo 2^32, to the rt index. A signed overflow is not reported and still writes.
- R5: Opcode 0x00 with funct (bits 5:0) 0x00, 0x02 or 0x03 is a fixed shift (left logical, right logical, right arithmetic). It shifts `src_b` by the shamt field (bits 10:6) and writes the rd index (bits 15:11). `src_a` and the rs field have no effect.
- R6: Opcode 0x00 with funct 0x04, 0x06 or 0x07 is a variable shift of `src_b` (left logical, right logical, right arithmetic). The amount is `src_a[4:0]`, `src_a[31:5]` and the shamt field are ignored, and the rd index is written.
- R7: A right logical shift fills the vacated upper bits with 0. A right arithmetic shift fills them with `src_b[31]`. A left shift fills the vacated lower bits with 0.
- R8: A shift amount of 0 returns `src_b` unchanged, and an amount of 31 leaves only one original bit in the result. For example, 0x77 shifted left by 3 gives 0x000003B8, and 3 shifted right logically by 2 gives 0.
- R9: Any other opcode, or opcode 0x00 with any other funct, gives `wr_en` = 0, `wr_idx` = 0 and `wr_data` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word to execute |
| src_a | input | 32 | Value of the register named by bits 25:21 |
| src_b | input | 32 | Value of the register named by bits 20:16 |
| wr_idx | output | 5 | Destination register number |
| wr_en | output | 1 | Write-back strobe |
| wr_data | output | 32 | Value to write back |

## Verification
Two sources of shift amount meet in every register-format word: the shamt field and the low bits of `src_a`. Only one of them may steer the shifter for a given funct. The bench builds words in which both carry different non-zero amounts, and `src_a` also carries set bits above bit 4. It then confirms that fixed shifts follow the field and variable shifts follow the register's low five bits. Each expected value is computed in the bench with the language's own shift operators.

// File: rtl/exu_pkg.sv
package exu_pkg;
    localparam int XLEN   = 32;
    localparam int SH_W   = $clog2(XLEN);
    localparam int OPC_W  = 6;
    localparam int REG_W  = 5;
    localparam int IMM_W  = 16;
    localparam int FN_W   = 6;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

    localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
    localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
    localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
    localparam logic [FN_W-1:0] FN_SLLV = 6'h04;
    localparam logic [FN_W-1:0] FN_SRLV = 6'h06;
    localparam logic [FN_W-1:0] FN_SRAV = 6'h07;

    typedef enum logic [3:0] {
        K_NONE, K_LUI, K_ADDI, K_ANDI, K_ORI,
        K_SLL, K_SRL, K_SRA, K_SLLV, K_SRLV, K_SRAV
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic [REG_W-1:0]   rs;
        logic [REG_W-1:0]   rt;
        logic [REG_W-1:0]   rd;
        logic [SH_W-1:0]    shamt;
        logic [IMM_W-1:0]   imm;
    } dec_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);
    logic [OPC_W-1:0] opc;
    logic [FN_W-1:0]  fn;
    kind_e            kind;

    assign opc = instr[XLEN-1 -: OPC_W];
    assign fn  = instr[FN_W-1:0];

    always_comb begin
        kind = K_NONE;
        unique case (opc)
            OPC_LUI:  kind = K_LUI;
            OPC_ADDI: kind = K_ADDI;
            OPC_ANDI: kind = K_ANDI;
            OPC_ORI:  kind = K_ORI;
            OPC_REG: begin
                unique case (fn)
                    FN_SLL:  kind = K_SLL;
                    FN_SRL:  kind = K_SRL;
                    FN_SRA:  kind = K_SRA;
                    FN_SLLV: kind = K_SLLV;
                    FN_SRLV: kind = K_SRLV;
                    FN_SRAV: kind = K_SRAV;
                    default: kind = K_NONE;
                endcase
            end
            default:  kind = K_NONE;
        endcase
    end

    always_comb begin
        dec.kind  = kind;
        dec.rs    = instr[25:21];
        dec.rt    = instr[20:16];
        dec.rd    = instr[15:11];
        dec.shamt = instr[10:6];
        dec.imm   = instr[IMM_W-1:0];
    end
endmodule

// File: rtl/exu_shifter.sv
module exu_shifter #(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          left,
    input  logic          arith,
    output logic [W-1:0]  dout
);
    logic          fill;
    logic [W-1:0]  stg [SW+1];

    assign fill   = arith & ~left & din[W-1];
    assign stg[0] = din;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int D = 1 << k;
        logic [2*W-1:0] wide;
        logic [W-1:0]   to_left;
        logic [W-1:0]   to_right;
        assign wide     = {{W{fill}}, stg[k]};
        assign to_right = wide[D +: W];
        assign to_left  = {stg[k][W-1-D:0], {D{1'b0}}};
        assign stg[k+1] = amt[k] ? (left ? to_left : to_right) : stg[k];
    end

    assign dout = stg[SW];

    always_comb begin
        if (!$isunknown({din, amt, left, arith})) begin
            // R8
            zero_amt_pass_chk: assert (amt != '0 || dout == din);
            // R7
            sign_fill_chk: assert (left || amt == '0 || dout[W-1] == (arith & din[W-1]));
        end
    end
endmodule

// File: rtl/exu_imm_alu.sv
module exu_imm_alu
    import exu_pkg::*;
(
    input  kind_e             kind,
    input  logic [XLEN-1:0]   a,
    input  logic [IMM_W-1:0]  imm,
    output logic [XLEN-1:0]   res
);
    logic [XLEN-1:0] imm_zx;
    logic [XLEN-1:0] imm_sx;

    assign imm_zx = {{(XLEN-IMM_W){1'b0}}, imm};
    assign imm_sx = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

    always_comb begin
        res = '0;
        unique case (kind)
            K_LUI:   res = {imm, {(XLEN-IMM_W){1'b0}}};
            K_ADDI:  res = a + imm_sx;
            K_ANDI:  res = a & imm_zx;
            K_ORI:   res = a | imm_zx;
            default: res = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({kind, a, imm})) begin
            // R2
            andi_upper_zero_chk: assert (kind != K_ANDI || res[XLEN-1:IMM_W] == '0);
            // R3
            ori_upper_keep_chk: assert (kind != K_ORI || res[XLEN-1:IMM_W] == a[XLEN-1:IMM_W]);
        end
    end
endmodule

// File: rtl/exu_imm_shift.sv
module exu_imm_shift
    import exu_pkg::*;
(
    input  logic [31:0] instr,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    output logic [4:0]  wr_idx,
    output logic        wr_en,
    output logic [31:0] wr_data
);
    dec_t            dec;
    logic [XLEN-1:0] imm_res;
    logic [XLEN-1:0] sh_res;
    logic [SH_W-1:0] sh_amt;
    logic            sh_left;
    logic            sh_arith;
    logic            sh_var;

    exu_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    exu_imm_alu u_alu (
        .kind (dec.kind),
        .a    (src_a),
        .imm  (dec.imm),
        .res  (imm_res)
    );

    assign sh_var   = (dec.kind == K_SLLV) || (dec.kind == K_SRLV) || (dec.kind == K_SRAV);
    assign sh_left  = (dec.kind == K_SLL)  || (dec.kind == K_SLLV);
    assign sh_arith = (dec.kind == K_SRA)  || (dec.kind == K_SRAV);
    assign sh_amt   = sh_var ? src_a[SH_W-1:0] : dec.shamt;

    exu_shifter #(.W(XLEN)) u_shf (
        .din   (src_b),
        .amt   (sh_amt),
        .left  (sh_left),
        .arith (sh_arith),
        .dout  (sh_res)
    );

    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = '0;
        wr_data = '0;
        unique case (dec.kind)
            K_LUI, K_ADDI, K_ANDI, K_ORI: begin
                wr_en   = 1'b1;
                wr_idx  = dec.rt;
                wr_data = imm_res;
            end
            K_SLL, K_SRL, K_SRA, K_SLLV, K_SRLV, K_SRAV: begin
                wr_en   = 1'b1;
                wr_idx  = dec.rd;
                wr_data = sh_res;
            end
            default: begin
                wr_en   = 1'b0;
                wr_idx  = '0;
                wr_data = '0;
            end
        endcase
    end

    always_comb begin
        if (!$isunknown({instr, src_a, src_b})) begin
            // R9
            none_quiet_chk: assert (dec.kind != K_NONE || (!wr_en && wr_idx == '0 && wr_data == '0));
            // R1
            lui_low_zero_chk: assert (!(wr_en && instr[31:26] == OPC_LUI) || wr_data[15:0] == '0);
            // R5
            reg_dest_chk: assert (!(wr_en && instr[31:26] == OPC_REG) || wr_idx == instr[15:11]);
            // R4
            imm_dest_chk: assert (!(wr_en && instr[31:26] != OPC_REG) || wr_idx == instr[20:16]);
        end
    end
endmodule

// File: tb/exu_imm_shift_tb.sv
module exu_imm_shift_tb_top;
    logic        clk = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [4:0]  wr_idx;
    logic        wr_en;
    logic [31:0] wr_data;
    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    exu_imm_shift dut_i (
        .instr(instr), .src_a(src_a), .src_b(src_b),
        .wr_idx(wr_idx), .wr_en(wr_en), .wr_data(wr_data)
    );

    function automatic logic [31:0] rw(input logic [4:0] rs, input logic [4:0] rt,
                                       input logic [4:0] rd, input logic [4:0] sh,
                                       input logic [5:0] fn);
        return {6'h00, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] iw(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic apply(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        #1;
        instr = w; src_a = a; src_b = b;
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic en, input logic [4:0] idx,
                              input logic [31:0] data);
        n_cmp++;
        if (wr_en !== en || wr_idx !== idx || wr_data !== data) begin
            n_bad++;
            $display("FAIL %s: got en=%0b idx=%0d data=%08h, expected en=%0b idx=%0d data=%08h",
                     req, wr_en, wr_idx, wr_data, en, idx, data);
        end
    endtask

    task automatic t_reset_state();
        apply('0, '0, '0);
        expect_out("R5 all-zero word", 1'b1, 5'd0, 32'h0);
    endtask

    task automatic t_lui();
        apply(iw(6'h0F, 5'd3, 5'd9, 16'h7F40), 32'hFFFF_FFFF, 32'h1234_5678);
        expect_out("R1 lui", 1'b1, 5'd9, 32'h7F40_0000);
        apply(iw(6'h0F, 5'd0, 5'd1, 16'h76B5), '0, '0);
        expect_out("R1 lui 2", 1'b1, 5'd1, 32'h76B5_0000);
    endtask

    task automatic t_andi_ori();
        logic [31:0] a = 32'h7F40_0777;
        apply(iw(6'h0C, 5'd2, 5'd11, 16'h5555), a, '0);
        expect_out("R2 andi", 1'b1, 5'd11, a & 32'h0000_5555);
        apply(iw(6'h0C, 5'd2, 5'd11, 16'hFFFF), 32'hDEAD_BEEF, '0);
        expect_out("R2 andi high imm", 1'b1, 5'd11, 32'h0000_BEEF);
        apply(iw(6'h0D, 5'd2, 5'd12, 16'h5555), a, '0);
        expect_out("R3 ori", 1'b1, 5'd12, a | 32'h0000_5555);
        apply(iw(6'h0D, 5'd1, 5'd8, 16'h2134), 32'h76B5_0000, '0);
        expect_out("R3 ori build constant", 1'b1, 5'd8, 32'h76B5_2134);
    endtask

    task automatic t_addi();
        apply(iw(6'h08, 5'd9, 5'd10, 16'h0777), 32'h7F40_0000, '0);
        expect_out("R4 addi pos", 1'b1, 5'd10, 32'h7F40_0777);
        apply(iw(6'h08, 5'd9, 5'd10, 16'hFFFF), 32'h0000_0005, '0);
        expect_out("R4 addi neg", 1'b1, 5'd10, 32'h0000_0004);
        apply(iw(6'h08, 5'd9, 5'd10, 16'h0001), 32'h7FFF_FFFF, '0);
        expect_out("R4 addi overflow wraps", 1'b1, 5'd10, 32'h8000_0000);
    endtask

    task automatic t_fixed_shift();
        apply(rw(5'd31, 5'd8, 5'd8, 5'd3, 6'h00), 32'hFFFF_FFFF, 32'h77);
        expect_out("R8 sll example", 1'b1, 5'd8, 32'h0000_03B8);
        apply(rw(5'd0, 5'd10, 5'd10, 5'd2, 6'h02), 32'h1, 32'h3);
        expect_out("R8 srl example", 1'b1, 5'd10, 32'h0);
        apply(rw(5'd7, 5'd4, 5'd17, 5'd4, 6'h03), 32'h0000_0001, 32'h8765_4321);
        expect_out("R7 sra sign fill", 1'b1, 5'd17, $signed(32'h8765_4321) >>> 4);
        apply(rw(5'd7, 5'd4, 5'd17, 5'd4, 6'h02), 32'h0000_0001, 32'h8765_4321);
        expect_out("R7 srl zero fill", 1'b1, 5'd17, 32'h8765_4321 >> 4);
    endtask

    task automatic t_var_shift();
        logic [31:0] a = 32'hFFFF_FFE5;
        apply(rw(5'd1, 5'd2, 5'd3, 5'd2, 6'h04), a, 32'h0000_00F1);
        expect_out("R6 sllv", 1'b1, 5'd3, 32'h0000_00F1 << 5);
        apply(rw(5'd1, 5'd2, 5'd3, 5'd9, 6'h06), a, 32'hF000_0000);
        expect_out("R6 srlv", 1'b1, 5'd3, 32'hF000_0000 >> 5);
        apply(rw(5'd1, 5'd2, 5'd3, 5'd1, 6'h07), a, 32'hF000_0000);
        expect_out("R6 srav", 1'b1, 5'd3, $signed(32'hF000_0000) >>> 5);
        apply(rw(5'd1, 5'd2, 5'd3, 5'd7, 6'h00), a, 32'h0000_00F1);
        expect_out("R5 sll ignores src_a", 1'b1, 5'd3, 32'h0000_00F1 << 7);
    endtask

    task automatic t_edges();
        apply(rw(5'd0, 5'd2, 5'd6, 5'd0, 6'h03), '0, 32'h8000_1234);
        expect_out("R8 amount zero", 1'b1, 5'd6, 32'h8000_1234);
        apply(rw(5'd0, 5'd2, 5'd6, 5'd31, 6'h03), '0, 32'h8000_0000);
        expect_out("R8 sra by 31", 1'b1, 5'd6, 32'hFFFF_FFFF);
        apply(rw(5'd0, 5'd2, 5'd6, 5'd31, 6'h00), '0, 32'h0000_0003);
        expect_out("R8 sll by 31", 1'b1, 5'd6, 32'h8000_0000);
        apply(rw(5'd0, 5'd2, 5'd6, 5'd0, 6'h06), 32'h0000_0020, 32'h5A5A_5A5A);
        expect_out("R6 register amount 32 uses low bits", 1'b1, 5'd6, 32'h5A5A_5A5A);
    endtask

    task automatic t_unsupported();
        apply(iw(6'h23, 5'd1, 5'd2, 16'h0004), 32'h1, 32'h2);
        expect_out("R9 bad opcode", 1'b0, 5'd0, 32'h0);
        apply(rw(5'd1, 5'd2, 5'd3, 5'd4, 6'h20), 32'h1, 32'h2);
        expect_out("R9 bad funct", 1'b0, 5'd0, 32'h0);
        apply(rw(5'd1, 5'd2, 5'd3, 5'd4, 6'h01), 32'h1, 32'h2);
        expect_out("R9 funct gap", 1'b0, 5'd0, 32'h0);
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_lui();
                t_andi_ori();
                t_addi();
                t_fixed_shift();
                t_var_shift();
                t_edges();
                t_unsupported();
            end
            begin
                repeat (5000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule